// File: doc/BRIEF.md
# Split-Phase Result Buffer with Packed Drain

This block holds a long stream of result symbols in a local store that has room for only half of them. The producer works in two time-separated phases. During the first phase it touches only the lower half of the global index range. During the second phase it touches only the upper half. Each access is a single-cycle read or write keyed by global index. The block translates the index to a local word, which lets the producer run an in-place accumulate: it reads a word, adds to it, and writes it back.

When the producer signals that a phase is finished, the block drains the whole local store to a wide global write channel. Each beat carries PACK symbols, and the channel uses a valid/ready handshake. Destination addresses are in beat units and start at a base address plus an offset for the phase. Drained words are zeroed as they go, so the second phase starts from a clean store. A one-cycle completion pulse marks the end of the second drain.

The controller has three states. FILL accepts symbol accesses. FLUSH drains the store. FINISHED is idle until reset. The transitions are:
- FILL→FLUSH on a phase-done pulse.
- FLUSH→FILL when the last beat of the first drain is accepted; the phase advances to the upper half.
- FLUSH→FINISHED when the last beat of the second drain is accepted.

Top module: `split_buf`

## Requirements
- R1: After reset the controller is in FILL for the lower half, every store word reads zero, and busy, bw_valid, run_done, phase_err, sym_rvalid and reject_cnt are all zero.
- R2: In the first phase, global indices 0 to HALF-1 address local words 0 to HALF-1. In the second phase, indices HALF to TOTAL-1 address local word index-HALF.
- R3: An accepted read (sym_we=0) returns the word on sym_rdata with sym_rvalid high one cycle later. A read issued the cycle after a write to the same index returns the written value.
- R4: An access in FILL whose index lies outside the current phase's half is not performed, gives no sym_rvalid, and increments reject_cnt by one.
- R5: A phase_done pulse in FILL moves the block to FLUSH. While flushing, busy is high and every access is refused: nothing is written, no sym_rvalid is given, and reject_cnt is not counted.
- R6: Beat b of a drain carries local word b*PACK+k in bits [k*SYM_W +: SYM_W] for lane k. Beats leave in ascending b.
- R7: With base_addr held constant, beat b of phase p is presented at address base_addr + p*BEATS + b, and the address advances by one per accepted beat.
- R8: While bw_valid is high and bw_ready is low, bw_addr and bw_data hold steady. No beat is dropped or repeated.
- R9: Each drain emits exactly BEATS=HALF/PACK beats. Each drained word reads zero afterwards. After the first drain the block returns to FILL for the upper half.
- R10: A phase_done pulse during FLUSH sets phase_err, which stays high until reset.
- R11: Acceptance of the last beat of the second drain raises run_done for exactly one cycle. From then on, accesses and phase_done have no effect.
- R12: Over a full run, the global words written equal the complete TOTAL-symbol result array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Symbol access request |
| sym_we | input | 1 | 1 = write, 0 = read |
| sym_idx | input | $clog2(TOTAL) | Global symbol index |
| sym_wdata | input | SYM_W | Write data |
| sym_rvalid | output | 1 | Read data valid (one cycle after request) |
| sym_rdata | output | SYM_W | Read data |
| phase_done | input | 1 | Producer finished the current phase |
| busy | output | 1 | Drain in progress; accesses refused |
| phase_err | output | 1 | Sticky: phase_done seen during a drain |
| reject_cnt | output | CNT_W | Count of out-of-half accesses |
| base_addr | input | ADDR_W | Global base address in beat units |
| bw_valid | output | 1 | Beat valid |
| bw_ready | input | 1 | Beat accepted by sink |
| bw_addr | output | ADDR_W | Beat destination address |
| bw_data | output | SYM_W*PACK | Packed beat of PACK symbols |
| run_done | output | 1 | One-cycle pulse after the second drain |

## Verification
Assertions check several properties on every cycle:
- beat address and data hold under back-pressure, and the address steps by one after each accepted beat;
- no access produces read data while busy;
- run_done never lasts two cycles, and phase_err never falls;
- the store never sees a write and a drain clear in the same cycle.

Other properties only the bench scenarios can show:
- the index-to-word mapping in each phase;
- the read-modify-write results;
- the reject count;
- the lane packing;
- the clearing of drained words;
- the equality of the whole global image with the expected symbol array under an irregular ready pattern.

// File: rtl/split_buf_pkg.sv
package split_buf_pkg;

    typedef enum logic [1:0] {
        ST_FILL     = 2'd0,
        ST_FLUSH    = 2'd1,
        ST_FINISHED = 2'd2
    } buf_state_e;

endpackage

// File: rtl/split_buf_store.sv
module split_buf_store #(
    parameter int SYM_W = 16,
    parameter int HALF  = 32,
    parameter int PACK  = 8,
    localparam int LADDR_W = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int BEATS   = HALF / PACK,
    localparam int BI_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic                  re,
    input  logic [LADDR_W-1:0]    addr,
    input  logic [SYM_W-1:0]      wdata,
    output logic                  rvalid,
    output logic [SYM_W-1:0]      rdata,
    input  logic                  clr_en,
    input  logic [BI_W-1:0]       beat_sel,
    output logic [SYM_W*PACK-1:0] beat_data
);

    logic [SYM_W-1:0] mem [HALF];

    // one register per word: written by the producer, zeroed when drained
    for (genvar g = 0; g < HALF; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && addr == LADDR_W'(g)) begin
                mem[g] <= wdata;
            end else if (clr_en && beat_sel == BI_W'(g / PACK)) begin
                mem[g] <= '0;
            end
        end
    end

    // lane k of the current beat
    for (genvar k = 0; k < PACK; k++) begin : g_lane
        logic [LADDR_W-1:0] lane_addr;
        assign lane_addr = LADDR_W'(32'(beat_sel) * PACK + k);
        assign beat_data[k*SYM_W +: SYM_W] = mem[lane_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= re;
            if (re) begin
                rdata <= mem[addr];
            end
        end
    end

    // R9: producer writes and drain clears never collide
    a_r9_no_write_while_clearing: assert property (
        @(posedge clk) disable iff (!rst_n) !(we && clr_en)
    );

endmodule

// File: rtl/split_buf_ctrl.sv
module split_buf_ctrl
    import split_buf_pkg::*;
#(
    parameter int TOTAL  = 64,
    parameter int PACK   = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int HALF    = TOTAL / 2,
    localparam int GIDX_W  = $clog2(TOTAL),
    localparam int LADDR_W = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int BEATS   = HALF / PACK,
    localparam int BI_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_valid,
    input  logic               sym_we,
    input  logic [GIDX_W-1:0]  sym_idx,
    input  logic               phase_done,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic               bw_ready,
    output logic               mem_we,
    output logic               mem_re,
    output logic [LADDR_W-1:0] mem_addr,
    output logic               clr_en,
    output logic [BI_W-1:0]    beat_sel,
    output logic               busy,
    output logic               phase_err,
    output logic [CNT_W-1:0]   reject_cnt,
    output logic               bw_valid,
    output logic [ADDR_W-1:0]  bw_addr,
    output logic               run_done
);

    buf_state_e         state_q, state_d;
    logic               phase_q;
    logic [BI_W-1:0]    beat_q;
    logic [GIDX_W:0]    lo_idx, hi_idx, idx_ext;
    logic               in_half, in_fill, beat_fire, last_beat;

    // window of the current phase
    always_comb begin
        idx_ext  = {1'b0, sym_idx};
        lo_idx   = phase_q ? (GIDX_W+1)'(HALF) : '0;
        hi_idx   = lo_idx + (GIDX_W+1)'(HALF);
        in_half  = (idx_ext >= lo_idx) && (idx_ext < hi_idx);
        mem_addr = LADDR_W'(idx_ext - lo_idx);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:     if (phase_done) state_d = ST_FLUSH;
            ST_FLUSH:    if (beat_fire && last_beat) state_d = phase_q ? ST_FINISHED : ST_FILL;
            ST_FINISHED: state_d = ST_FINISHED;
            default:     state_d = ST_FILL;
        endcase
    end

    // outputs
    always_comb begin
        in_fill   = (state_q == ST_FILL);
        busy      = (state_q == ST_FLUSH);
        bw_valid  = busy;
        beat_fire = busy && bw_ready;
        last_beat = (beat_q == BI_W'(BEATS - 1));
        mem_we    = in_fill && sym_valid && in_half && sym_we;
        mem_re    = in_fill && sym_valid && in_half && !sym_we;
        clr_en    = beat_fire;
        beat_sel  = beat_q;
        bw_addr   = base_addr + (phase_q ? ADDR_W'(BEATS) : '0) + ADDR_W'(beat_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= 1'b0;
            beat_q     <= '0;
            phase_err  <= 1'b0;
            reject_cnt <= '0;
            run_done   <= 1'b0;
        end else begin
            run_done <= beat_fire && last_beat && phase_q;
            if (beat_fire) begin
                beat_q <= last_beat ? '0 : beat_q + BI_W'(1);
                if (last_beat) phase_q <= 1'b1;
            end
            if (busy && phase_done) phase_err <= 1'b1;
            if (in_fill && sym_valid && !in_half) reject_cnt <= reject_cnt + CNT_W'(1);
        end
    end

    // R10: the error flag never falls once raised
    a_r10_err_sticky: assert property (
        @(posedge clk) disable iff (!rst_n) phase_err |=> phase_err
    );

    // R7: after an accepted beat the next presented beat is one address higher
    a_r7_addr_step: assert property (
        @(posedge clk) disable iff (!rst_n)
        (bw_valid && bw_ready) |=> (!bw_valid || bw_addr == $past(bw_addr) + ADDR_W'(1))
    );

endmodule

// File: rtl/split_buf.sv
module split_buf #(
    parameter int TOTAL  = 64,
    parameter int SYM_W  = 16,
    parameter int PACK   = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int HALF    = TOTAL / 2,
    localparam int GIDX_W  = $clog2(TOTAL),
    localparam int LADDR_W = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int BEATS   = HALF / PACK,
    localparam int BI_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sym_valid,
    input  logic                  sym_we,
    input  logic [GIDX_W-1:0]     sym_idx,
    input  logic [SYM_W-1:0]      sym_wdata,
    output logic                  sym_rvalid,
    output logic [SYM_W-1:0]      sym_rdata,
    input  logic                  phase_done,
    output logic                  busy,
    output logic                  phase_err,
    output logic [CNT_W-1:0]      reject_cnt,
    input  logic [ADDR_W-1:0]     base_addr,
    output logic                  bw_valid,
    input  logic                  bw_ready,
    output logic [ADDR_W-1:0]     bw_addr,
    output logic [SYM_W*PACK-1:0] bw_data,
    output logic                  run_done
);

    logic               mem_we, mem_re, clr_en;
    logic [LADDR_W-1:0] mem_addr;
    logic [BI_W-1:0]    beat_sel;

    split_buf_ctrl #(
        .TOTAL(TOTAL), .PACK(PACK), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .sym_valid(sym_valid), .sym_we(sym_we), .sym_idx(sym_idx),
        .phase_done(phase_done), .base_addr(base_addr), .bw_ready(bw_ready),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .clr_en(clr_en), .beat_sel(beat_sel),
        .busy(busy), .phase_err(phase_err), .reject_cnt(reject_cnt),
        .bw_valid(bw_valid), .bw_addr(bw_addr), .run_done(run_done)
    );

    split_buf_store #(
        .SYM_W(SYM_W), .HALF(HALF), .PACK(PACK)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .re(mem_re), .addr(mem_addr), .wdata(sym_wdata),
        .rvalid(sym_rvalid), .rdata(sym_rdata),
        .clr_en(clr_en), .beat_sel(beat_sel), .beat_data(bw_data)
    );

    // R8: a stalled beat holds address and data
    a_r8_hold_under_stall: assert property (
        @(posedge clk) disable iff (!rst_n)
        (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_addr) && $stable(bw_data))
    );

    // R5: an access while draining yields no read data
    a_r5_refuse_when_busy: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && sym_valid) |=> !sym_rvalid
    );

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (
        @(posedge clk) disable iff (!rst_n) run_done |=> !run_done
    );

endmodule

// File: tb/split_buf_tb_top.sv
module split_buf_tb_top;

    localparam int TOTAL = 64, SYM_W = 16, PACK = 8, ADDR_W = 16, CNT_W = 16;
    localparam int HALF = TOTAL / 2, BEATS = HALF / PACK, GIDX_W = $clog2(TOTAL);
    localparam logic [ADDR_W-1:0] BASE = 16'h0100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sym_valid = 1'b0, sym_we = 1'b0, phase_done = 1'b0, bw_ready = 1'b0;
    logic [GIDX_W-1:0] sym_idx = '0;
    logic [SYM_W-1:0]  sym_wdata = '0;
    logic [ADDR_W-1:0] base_addr = BASE;
    logic sym_rvalid, busy, phase_err, bw_valid, run_done;
    logic [SYM_W-1:0] sym_rdata;
    logic [CNT_W-1:0] reject_cnt;
    logic [ADDR_W-1:0] bw_addr;
    logic [SYM_W*PACK-1:0] bw_data;

    always #2 clk = ~clk;

    split_buf #(.TOTAL(TOTAL), .SYM_W(SYM_W), .PACK(PACK), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_we(sym_we),
        .sym_idx(sym_idx), .sym_wdata(sym_wdata), .sym_rvalid(sym_rvalid),
        .sym_rdata(sym_rdata), .phase_done(phase_done), .busy(busy),
        .phase_err(phase_err), .reject_cnt(reject_cnt), .base_addr(base_addr),
        .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr),
        .bw_data(bw_data), .run_done(run_done)
    );

    int tests = 0, fails = 0, beats_rx = 0;
    bit finished = 1'b0;
    logic [SYM_W*PACK-1:0] gmem [2*BEATS];
    bit gseen [2*BEATS];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expv(input int g);
        return 6 * g + 1001;
    endfunction

    // sink model: irregular ready, records accepted beats
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            bw_ready = (cyc % 3 == 0);
            #1;
            if (rst_n && bw_valid && bw_ready) begin
                int slot;
                slot = int'(bw_addr) - int'(BASE);
                beats_rx++;
                if (slot < 0 || slot >= 2 * BEATS) begin
                    chk(1'b0, "R7 beat address in range", int'(bw_addr), int'(BASE));
                end else begin
                    if (gseen[slot]) chk(1'b0, "R8 beat repeated", slot, -1);
                    gseen[slot] = 1'b1;
                    gmem[slot]  = bw_data;
                end
            end
        end
    end

    task automatic access(input bit we, input int idx, input int wd);
        @(negedge clk);
        sym_valid = 1'b1; sym_we = we;
        sym_idx = GIDX_W'(idx); sym_wdata = SYM_W'(wd);
        @(negedge clk);
        sym_valid = 1'b0; sym_we = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        phase_done = 1'b1;
        @(negedge clk);
        phase_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2 * BEATS; s++) begin gseen[s] = 1'b0; gmem[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !bw_valid && !run_done && !phase_err && !sym_rvalid,
            "R1 outputs idle after reset", int'({busy, bw_valid, run_done, phase_err, sym_rvalid}), 0);
        chk(reject_cnt == 0, "R1 reject count zero", int'(reject_cnt), 0);
        access(1'b0, 17, 0);
        chk(sym_rvalid && sym_rdata == 0, "R1 store reads zero", int'(sym_rdata), 0);

        // R2/R3 phase 0: fill, then read-modify-write every word
        for (int i = 0; i < HALF; i++) access(1'b1, i, 5 * i + 1);
        for (int i = 0; i < HALF; i++) begin
            int rd;
            access(1'b0, i, 0);
            rd = int'(sym_rdata);
            chk(sym_rvalid && rd == 5 * i + 1, "R2 lower-half word read back", rd, 5 * i + 1);
            access(1'b1, i, rd + 1000 + i);
        end
        access(1'b0, 7, 0);
        chk(sym_rvalid && sym_rdata == SYM_W'(expv(7)), "R3 read after write", int'(sym_rdata), expv(7));

        // R4 out-of-half accesses
        access(1'b1, 40, 9);
        chk(!sym_rvalid && reject_cnt == 1, "R4 upper write rejected in phase 0", int'(reject_cnt), 1);
        access(1'b0, 63, 0);
        chk(!sym_rvalid && reject_cnt == 2, "R4 upper read rejected in phase 0", int'(reject_cnt), 2);
        access(1'b0, 8, 0);
        chk(sym_rdata == SYM_W'(expv(8)), "R4 in-half word untouched", int'(sym_rdata), expv(8));

        // R5 / R10 first drain
        pulse_done();
        chk(busy && bw_valid, "R5 busy after phase_done", int'(busy), 1);
        sym_valid = 1'b1; sym_we = 1'b0; sym_idx = GIDX_W'(5);
        @(negedge clk);
        sym_valid = 1'b0;
        chk(!sym_rvalid, "R5 read refused while busy", int'(sym_rvalid), 0);
        sym_valid = 1'b1; sym_we = 1'b1; sym_idx = GIDX_W'(3); sym_wdata = 16'hDEAD;
        @(negedge clk);
        sym_valid = 1'b0; sym_we = 1'b0;
        phase_done = 1'b1;
        @(negedge clk);
        phase_done = 1'b0;
        chk(phase_err, "R10 phase_done during drain flags error", int'(phase_err), 1);
        chk(reject_cnt == 2, "R5 refused accesses not counted", int'(reject_cnt), 2);
        for (int w = 0; w < 200 && busy; w++) @(negedge clk);
        chk(!busy, "R9 first drain ends in FILL", int'(busy), 0);
        chk(beats_rx == BEATS, "R9 beat count of first drain", beats_rx, BEATS);

        // R2 / R9 phase 1
        access(1'b0, 0, 0);
        chk(!sym_rvalid && reject_cnt == 3, "R2 lower index rejected in phase 1", int'(reject_cnt), 3);
        access(1'b0, HALF, 0);
        chk(sym_rvalid && sym_rdata == 0, "R9 drained word cleared", int'(sym_rdata), 0);
        for (int i = HALF; i < TOTAL; i++) access(1'b1, i, expv(i));
        access(1'b0, TOTAL - 1, 0);
        chk(sym_rvalid && sym_rdata == SYM_W'(expv(TOTAL - 1)), "R2 upper-half top word",
            int'(sym_rdata), expv(TOTAL - 1));
        pulse_done();
        begin
            int w = 0;
            while (!run_done && w < 200) begin @(negedge clk); w++; end
        end
        chk(run_done, "R11 completion pulse seen", int'(run_done), 1);
        @(negedge clk);
        chk(!run_done && !busy, "R11 completion pulse one cycle", int'(run_done), 0);
        chk(beats_rx == 2 * BEATS, "R9 total beats over both drains", beats_rx, 2 * BEATS);

        // R6 / R12 global image
        for (int b = 0; b < 2 * BEATS; b++) begin
            chk(gseen[b], "R7 every beat address written", int'(gseen[b]), 1);
            for (int k = 0; k < PACK; k++) begin
                int g, got;
                g = b * PACK + k;
                got = int'(gmem[b][k*SYM_W +: SYM_W]);
                chk(got == expv(g), "R6 R12 global word matches", got, expv(g));
            end
        end

        // R11 idle after completion
        access(1'b1, 40, 7);
        access(1'b0, 40, 0);
        chk(!sym_rvalid && reject_cnt == 3, "R11 access ignored after completion", int'(reject_cnt), 3);
        pulse_done();
        repeat (6) @(negedge clk);
        chk(!bw_valid && beats_rx == 2 * BEATS, "R11 phase_done ignored after completion", beats_rx, 2 * BEATS);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule